// File: doc/BRIEF.md
# Physical Memory Attribute and Protection Checker

This block stands between a processor's physical-address request and the memory controller. It sorts every physical address into one of three attribute classes using a fixed address map built into the hardware: cached RAM, an uncached view of that same RAM, or unmapped space. In the same cycle it either grants the request, passing on a memory address, or raises a bus error so that the request never reaches memory. System software cannot change the address map.

The grant decision depends on the privilege of the requester. A machine-mode access to mapped space is always granted. A lower-privilege access to the uncached view is granted only if a control bit allows it. An optional trusted-fetch check can also be switched on. When it is on, a machine-mode grant also requires that the most recent instruction fetch came from a configured trusted address window. A small state machine tracks that fetch: it starts in `FT_NONE` after reset. On each fetch it moves to `FT_TRUSTED` if the fetch address lies inside the window, or to `FT_UNTRUSTED` if it does not. Both moves can be taken from any state. Only machine-mode writes can change the control bits and the window bounds.

Top module: `pmchk_top`

## Requirements
- R1: Addresses 0x00000000 to 0x003FFFFF report attribute code 2'b01 (cached). A granted access there presents the unchanged address on `mem_addr`.
- R2: Addresses 0x00800000 to 0x00BFFFFF report attribute code 2'b10 (uncached view). A granted access there presents the address with bit 23 cleared on `mem_addr`.
- R3: All other addresses report attribute code 2'b00 (unmapped). A valid request to them raises `bus_err` and not `grant`, at every privilege level.
- R4: `grant` and `bus_err` depend combinationally on the request in the same cycle. Exactly one of them is high when `req_valid` is high, and neither is high when it is low. `mem_addr` is zero whenever `grant` is low.
- R5: With control bit 1 (trusted-fetch enable) clear, a machine-mode request to a mapped address is granted.
- R6: A non-machine-mode request to the cached region is granted, whatever the control bits hold.
- R7: A non-machine-mode request to the uncached view is granted when control bit 0 is set. It raises `bus_err` when control bit 0 is clear.
- R8: With control bit 1 set, a machine-mode request is granted only if the last fetch recorded at an earlier clock edge had `fetch_pc` within the range lower bound to upper bound, both bounds included. Before any fetch has been recorded since reset, a machine-mode request raises `bus_err`.
- R9: A configuration write with `cfg_mmode` high takes effect from the next cycle. Select code 0 writes the control bits (`cfg_wdata[1:0]`), code 1 writes the lower bound and code 2 writes the upper bound. Code 3 changes nothing. None of these writes raises `cfg_err`.
- R10: A configuration write with `cfg_mmode` low changes nothing and raises `cfg_err` in the same cycle.
- R11: After reset the control bits are 0, both bounds are 0 and no fetch is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Physical address of the request |
| req_mmode | input | 1 | Request issued in machine mode |
| fetch_valid | input | 1 | An instruction fetch happens this cycle |
| fetch_pc | input | ADDR_W | Address of that fetch |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_mmode | input | 1 | Configuration write issued in machine mode |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 lower bound, 2 upper bound, 3 none |
| cfg_wdata | input | ADDR_W | Configuration write data |
| grant | output | 1 | Request forwarded to memory |
| bus_err | output | 1 | Request refused |
| attr | output | 2 | Attribute class of req_addr |
| mem_addr | output | ADDR_W | Address forwarded to memory, zero when not granted |
| cfg_err | output | 1 | Configuration write refused |

## Verification
Requests are swept over both edges of each region and over the gaps between and above the regions, in both privilege levels. This separates errors in the address decode from errors in the privilege rule. The control bit that opens the uncached view is toggled by writes from each privilege level. A refused write must leave the lower-privilege result unchanged, and an accepted write must flip it. With the trusted-fetch check on, fetches land just inside and just outside each bound of the window. One fetch and one request happen in the same cycle, which shows that the decision uses the fetch recorded at an earlier edge and not the one in the current cycle.

// File: rtl/pmchk_pkg.sv
package pmchk_pkg;
    typedef enum logic [1:0] {
        ATTR_NONE     = 2'b00,
        ATTR_CACHED   = 2'b01,
        ATTR_UNCACHED = 2'b10
    } attr_e;

    typedef enum logic [1:0] {
        FT_NONE      = 2'd0,
        FT_TRUSTED   = 2'd1,
        FT_UNTRUSTED = 2'd2
    } ft_state_e;

    localparam int CTRL_W      = 2;
    localparam int CTRL_UNC_OK = 0;
    localparam int CTRL_TF_EN  = 1;

    localparam logic [1:0] CSEL_CTRL = 2'd0;
    localparam logic [1:0] CSEL_LO   = 2'd1;
    localparam logic [1:0] CSEL_HI   = 2'd2;
endpackage

// File: rtl/pmchk_region_decode.sv
module pmchk_region_decode
    import pmchk_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] CACHED_BASE   = '0,
    parameter logic [ADDR_W-1:0] UNCACHED_BASE = ADDR_W'(32'h0080_0000),
    parameter logic [ADDR_W-1:0] REGION_BYTES  = ADDR_W'(32'h0040_0000)
) (
    input  logic [ADDR_W-1:0] addr,
    output attr_e             attr,
    output logic [ADDR_W-1:0] fwd_addr
);
    logic [ADDR_W-1:0] cached_off;
    logic [ADDR_W-1:0] uncached_off;

    assign cached_off   = addr - CACHED_BASE;
    assign uncached_off = addr - UNCACHED_BASE;

    always_comb begin
        attr     = ATTR_NONE;
        fwd_addr = '0;
        if (cached_off < REGION_BYTES) begin
            attr     = ATTR_CACHED;
            fwd_addr = addr;
        end else if (uncached_off < REGION_BYTES) begin
            attr     = ATTR_UNCACHED;
            fwd_addr = uncached_off + CACHED_BASE;
        end
    end
endmodule

// File: rtl/pmchk_cfg_regs.sv
module pmchk_cfg_regs
    import pmchk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_mmode,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [ADDR_W-1:0] lo_q,
    output logic [ADDR_W-1:0] hi_q,
    output logic              wr_err
);
    logic wr_ok;

    assign wr_ok  = wr_valid && wr_mmode;
    assign wr_err = wr_valid && !wr_mmode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (wr_ok) begin
            unique case (wr_sel)
                CSEL_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
                CSEL_LO:   lo_q   <= wr_data;
                CSEL_HI:   hi_q   <= wr_data;
                default:   ;
            endcase
        end
    end

    // R10
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_mmode) |=> ($stable(ctrl_q) && $stable(lo_q) && $stable(hi_q)));

    // R9
    reserved_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 2'd3) |=> ($stable(ctrl_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/pmchk_fetch_track.sv
module pmchk_fetch_track
    import pmchk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              trusted
);
    ft_state_e state_q, state_d;
    logic      in_window;

    assign in_window = (fetch_pc >= lo) && (fetch_pc <= hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FT_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FT_NONE, FT_TRUSTED, FT_UNTRUSTED:
                if (fetch_valid) state_d = in_window ? FT_TRUSTED : FT_UNTRUSTED;
            default: state_d = FT_NONE;
        endcase
    end

    assign trusted = (state_q == FT_TRUSTED);

    // R8
    fetch_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> (state_q != FT_NONE));

    // R8
    no_fetch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(state_q));
endmodule

// File: rtl/pmchk_top.sv
module pmchk_top
    import pmchk_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] CACHED_BASE   = '0,
    parameter logic [ADDR_W-1:0] UNCACHED_BASE = ADDR_W'(32'h0080_0000),
    parameter logic [ADDR_W-1:0] REGION_BYTES  = ADDR_W'(32'h0040_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_mmode,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              cfg_wr_valid,
    input  logic              cfg_mmode,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              grant,
    output logic              bus_err,
    output logic [1:0]        attr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cfg_err
);
    attr_e             region;
    logic [ADDR_W-1:0] fwd_addr;
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] win_lo, win_hi;
    logic              fetch_ok;
    logic              mm_ok;
    logic              allowed;

    pmchk_region_decode #(
        .ADDR_W(ADDR_W), .CACHED_BASE(CACHED_BASE),
        .UNCACHED_BASE(UNCACHED_BASE), .REGION_BYTES(REGION_BYTES)
    ) u_dec (
        .addr(req_addr), .attr(region), .fwd_addr(fwd_addr)
    );

    pmchk_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_valid(cfg_wr_valid), .wr_mmode(cfg_mmode),
        .wr_sel(cfg_sel), .wr_data(cfg_wdata), .ctrl_q(ctrl), .lo_q(win_lo),
        .hi_q(win_hi), .wr_err(cfg_err)
    );

    pmchk_fetch_track #(.ADDR_W(ADDR_W)) u_ft (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .lo(win_lo), .hi(win_hi), .trusted(fetch_ok)
    );

    assign mm_ok = !ctrl[CTRL_TF_EN] || fetch_ok;

    always_comb begin
        allowed = 1'b0;
        unique case (region)
            ATTR_CACHED:   allowed = req_mmode ? mm_ok : 1'b1;
            ATTR_UNCACHED: allowed = req_mmode ? mm_ok : ctrl[CTRL_UNC_OK];
            default:       allowed = 1'b0;
        endcase
    end

    assign grant    = req_valid && allowed;
    assign bus_err  = req_valid && !allowed;
    assign attr     = region;
    assign mem_addr = grant ? fwd_addr : '0;

    // R4
    grant_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && bus_err));

    // R3
    unmapped_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && region == ATTR_NONE) |-> bus_err);

    // R5
    mmode_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mmode && !ctrl[CTRL_TF_EN] && region != ATTR_NONE) |-> grant);

    // R4
    blocked_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (mem_addr == '0));
endmodule

// File: tb/sim_pmchk_top.sv
module sim_pmchk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_mmode = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        cfg_wr_valid = 1'b0;
    logic        cfg_mmode = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        grant, bus_err, cfg_err;
    logic [1:0]  attr;
    logic [31:0] mem_addr;

    int tests = 0;
    int fails = 0;

    logic [1:0]  m_ctrl = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_hi = '0;
    int          m_fetch = 0;

    always #5 clk = ~clk;

    pmchk_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mmode(req_mmode), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .cfg_wr_valid(cfg_wr_valid), .cfg_mmode(cfg_mmode), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .grant(grant), .bus_err(bus_err), .attr(attr),
        .mem_addr(mem_addr), .cfg_err(cfg_err)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic cyc(input string tag);
        logic [1:0]  e_attr;
        logic        e_grant, e_err, e_cerr;
        logic [31:0] e_maddr;
        #1;
        if (req_addr < 32'h0040_0000) e_attr = 2'b01;
        else if (req_addr >= 32'h0080_0000 && req_addr < 32'h00C0_0000) e_attr = 2'b10;
        else e_attr = 2'b00;
        if (!req_valid || e_attr == 2'b00) e_grant = 1'b0;
        else if (req_mmode) e_grant = !m_ctrl[1] || (m_fetch == 1);
        else e_grant = (e_attr == 2'b01) || m_ctrl[0];
        e_err   = req_valid && !e_grant;
        e_maddr = !e_grant ? 32'h0 : (e_attr == 2'b10 ? req_addr - 32'h0080_0000 : req_addr);
        e_cerr  = cfg_wr_valid && !cfg_mmode;
        tests++;
        if (grant !== e_grant || bus_err !== e_err || attr !== e_attr ||
            mem_addr !== e_maddr || cfg_err !== e_cerr) begin
            fails++;
            $display("FAIL %s addr=%h: actual g=%b e=%b a=%b m=%h c=%b expected g=%b e=%b a=%b m=%h c=%b",
                     tag, req_addr, grant, bus_err, attr, mem_addr, cfg_err,
                     e_grant, e_err, e_attr, e_maddr, e_cerr);
        end
        @(posedge clk);
        if (fetch_valid) m_fetch = (fetch_pc >= m_lo && fetch_pc <= m_hi) ? 1 : 2;
        if (cfg_wr_valid && cfg_mmode) begin
            case (cfg_sel)
                2'd0: m_ctrl = cfg_wdata[1:0];
                2'd1: m_lo = cfg_wdata;
                2'd2: m_hi = cfg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0; fetch_valid = 1'b0; cfg_wr_valid = 1'b0;
    endtask

    task automatic req(input logic [31:0] a, input logic mm, input string tag);
        req_valid = 1'b1; req_addr = a; req_mmode = mm;
        cyc(tag);
    endtask

    task automatic wcfg(input logic [1:0] sel, input logic [31:0] d, input logic mm, input string tag);
        cfg_wr_valid = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_mmode = mm;
        cyc(tag);
    endtask

    task automatic fetch(input logic [31:0] pc, input string tag);
        fetch_valid = 1'b1; fetch_pc = pc;
        cyc(tag);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cyc("R11 idle after reset");
        req(32'h0080_0000, 1'b0, "R11 uncached closed after reset");
        req(32'h0000_0000, 1'b0, "R1 cached low edge user");
        req(32'h003F_FFFF, 1'b1, "R1 cached high edge mmode");
        req(32'h0012_3456, 1'b0, "R6 cached user");
        req(32'h0040_0000, 1'b1, "R3 gap low mmode");
        req(32'h007F_FFFF, 1'b0, "R3 gap high user");
        req(32'h00C0_0000, 1'b1, "R3 above uncached mmode");
        req(32'hFFFF_FFFF, 1'b0, "R3 top user");
        req(32'h0080_0000, 1'b1, "R2 uncached low edge mmode");
        req(32'h00BF_FFFF, 1'b1, "R5 uncached high edge mmode");
        req(32'h00A0_1234, 1'b0, "R7 uncached user closed");
        req_addr = 32'h0080_0010; req_mmode = 1'b0;
        cyc("R4 no request");
        wcfg(2'd0, 32'h1, 1'b0, "R10 user write refused");
        req(32'h0080_0010, 1'b0, "R10 uncached still closed");
        wcfg(2'd3, 32'h3, 1'b1, "R9 reserved select");
        req(32'h0080_0010, 1'b0, "R9 reserved write no effect");
        wcfg(2'd0, 32'h1, 1'b1, "R9 mmode ctrl write");
        req(32'h0090_0000, 1'b0, "R7 uncached user open");
        req(32'h0010_0000, 1'b1, "R5 mmode check off");
        wcfg(2'd1, 32'h0000_1000, 1'b1, "R9 write lower bound");
        wcfg(2'd2, 32'h0000_1FFF, 1'b1, "R9 write upper bound");
        wcfg(2'd2, 32'h0000_0FFF, 1'b0, "R10 user bound write refused");
        wcfg(2'd0, 32'h3, 1'b1, "R9 enable trusted fetch");
        req(32'h0000_2000, 1'b1, "R8 no fetch yet");
        req(32'h0000_2000, 1'b0, "R6 user cached under check");
        fetch(32'h0000_1000, "R8 fetch at lower bound");
        req(32'h0000_2000, 1'b1, "R8 trusted lower bound");
        fetch(32'h0000_2000, "R8 fetch above window");
        req(32'h0080_0000, 1'b1, "R8 untrusted above");
        fetch(32'h0000_1FFF, "R8 fetch at upper bound");
        req(32'h0080_0000, 1'b1, "R8 trusted upper bound");
        fetch_valid = 1'b1; fetch_pc = 32'h0000_0FFF;
        req(32'h0000_0100, 1'b1, "R8 same-cycle fetch uses earlier one");
        req(32'h0000_0100, 1'b1, "R8 untrusted below");
        req(32'h0050_0000, 1'b1, "R3 unmapped under check");
        summary();
        $finish;
    end
endmodule